// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides which of two DMA channels owns a single shared bus, and sequences each granted transfer as two bus cycles. The first cycle reads at the channel's source pointer and the second writes at its destination pointer. Each channel chooses its request from its own request pin or from a shared internal timer request. It also has a priority bit and a synchronization mode. The block keeps a source and a destination pointer for every channel and steps both at the end of each write cycle. The step is up, down or none, by one or two.

A channel in destination-synchronized mode gives up the bus for two cycles after each write. If the other channel is waiting, it then gets exactly one transfer. This holds even when it has the lower priority. With both requests held, the two channels therefore take turns. Otherwise the higher-priority channel wins at every transfer boundary, and two channels of equal priority alternate. A transfer that has started always completes; decisions are taken only from idle, at the end of a write, or at the end of a release. There is no data stream at this block's edge: all pins are plain control and status levels sampled on the clock, so no back-pressure applies.

Top module: `dual_dma_arbiter`

## Requirements
- R1: After reset, phase is 0 (idle), grant is 0, bus_addr is 0 and all four pointers are 0.
- R2: Channel i's request is timer_req when req_sel[i] is 1 and pin_req[i] when it is 0. The unselected source has no effect, so the bus stays idle.
- R3: A transfer is one read cycle (phase 1, bus_addr = owner's source pointer), then in the next cycle one write cycle (phase 2, bus_addr = owner's destination pointer). grant is one-hot with bit i for channel i during both cycles, and it is unchanged between the two.
- R4: From idle, a visible request starts a read in the next cycle. A channel whose sync_mode is 0 (unsynchronized), 1 (source) or 3 starts its next read in the cycle right after its write while a request is present.
- R5: When both channels request at a decision point and their pri_hi bits differ, the channel with pri_hi = 1 transfers next. A higher-priority request raised during a lower-priority transfer takes the bus right after that transfer's write.
- R6: When both channels request with equal pri_hi, the channel that was not granted last transfers next.
- R7: After a write by a channel with sync_mode = 2 (destination), the next two cycles are release cycles: phase 3 with grant 0.
- R8: At the end of a release, if the other channel is requesting, it gets the next transfer regardless of priority. Otherwise normal arbitration applies, and with no request the bus goes idle.
- R9: At the end of each write, only the owner's pointers step. A 2-bit step field has code 0 = hold, 1 = add, 2 = subtract, 3 = hold. The step is 2 when the channel's word_size bit is 1 and 1 otherwise, wrapping modulo 2^AW.
- R10: ld_en[i] high for one cycle loads ld_src and ld_dst into channel i's pointers. A load takes precedence over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_req | input | 2 | Request pin per channel, bit i = channel i |
| timer_req | input | 1 | Shared internal timer request |
| req_sel | input | 2 | Per channel: 1 selects timer_req, 0 selects pin_req |
| pri_hi | input | 2 | Per channel priority bit, 1 = high |
| sync_mode | input | 4 | Per channel 2-bit mode at [2i+1:2i]: 0 none, 1 source, 2 destination |
| src_step | input | 4 | Per channel 2-bit source step code |
| dst_step | input | 4 | Per channel 2-bit destination step code |
| word_size | input | 2 | Per channel: 1 = step by 2, 0 = step by 1 |
| ld_en | input | 2 | Per channel pointer load strobe |
| ld_src | input | AW | Source pointer load value |
| ld_dst | input | AW | Destination pointer load value |
| grant | output | 2 | One-hot owner during read and write cycles |
| phase | output | 2 | 0 idle, 1 read, 2 write, 3 release |
| bus_addr | output | AW | Address of the current bus cycle, 0 when none |
| src_ptr | output | 2*AW | Source pointers, channel i at [AW*i +: AW] |
| dst_ptr | output | 2*AW | Destination pointers, channel i at [AW*i +: AW] |

## Verification
The bench builds the block with AW = 8. At that width, stepping a pointer past 0xFF or below 0x00 takes only a single transfer, so the modulo-wrap cases of R9 can be checked directly from loaded values. The bench still covers strict priority, round-robin ties, preemption at a boundary, timer-sourced requests and the alternation forced by destination-synchronized release. For each case it predicts the order of transfers, their addresses and the cycle spacing between successive writes.

// File: rtl/dual_dma_pkg.sv
package dual_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_REL_A = 3'd3,
    ST_REL_B = 3'd4
  } arb_state_e;

  localparam logic [1:0] PH_IDLE  = 2'd0;
  localparam logic [1:0] PH_READ  = 2'd1;
  localparam logic [1:0] PH_WRITE = 2'd2;
  localparam logic [1:0] PH_REL   = 2'd3;

  localparam logic [1:0] SYNC_DEST = 2'd2;
  localparam logic [1:0] STEP_UP   = 2'd1;
  localparam logic [1:0] STEP_DOWN = 2'd2;
endpackage

// File: rtl/dma_req_select.sv
module dma_req_select #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] pin_req,
  input  logic           timer_req,
  input  logic [NCH-1:0] req_sel,
  output logic [NCH-1:0] req
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign req[i] = req_sel[i] ? timer_req : pin_req[i];
  end
endmodule

// File: rtl/dma_ptr_pair.sv
module dma_ptr_pair
  import dual_dma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic          step,
  input  logic [1:0]    src_code,
  input  logic [1:0]    dst_code,
  input  logic          word,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q
);
  localparam logic [AW-1:0] INC1 = AW'(1);
  localparam logic [AW-1:0] INC2 = AW'(2);

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] p,
                                            input logic [1:0] code,
                                            input logic w);
    logic [AW-1:0] d;
    d = w ? INC2 : INC1;
    case (code)
      STEP_UP:   return p + d;
      STEP_DOWN: return p - d;
      default:   return p;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (load) begin
      src_q <= ld_src;
      dst_q <= ld_dst;
    end else if (step) begin
      src_q <= advance(src_q, src_code, word);
      dst_q <= advance(dst_q, dst_code, word);
    end
  end

  // R9: pointers move only on a step or a load
  assert_hold_when_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(src_q) && $stable(dst_q)));
endmodule

// File: rtl/dma_arb_fsm.sv
module dma_arb_fsm
  import dual_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic [1:0] pri_hi,
  input  logic [1:0] dst_sync,
  output logic       owner,
  output logic [1:0] grant,
  output logic [1:0] phase,
  output logic       write_done
);
  arb_state_e state, nxt;
  logic last;
  logic win;
  logic any_req;
  logic yield_now;

  always_comb begin
    any_req   = |req;
    yield_now = (state == ST_REL_B) && req[~owner];
    if (yield_now)
      win = ~owner;
    else if (req == 2'b11)
      win = (pri_hi[0] != pri_hi[1]) ? pri_hi[1] : ~last;
    else
      win = req[1];

    nxt = state;
    case (state)
      ST_IDLE:  nxt = any_req ? ST_READ : ST_IDLE;
      ST_READ:  nxt = ST_WRITE;
      ST_WRITE: begin
        if (dst_sync[owner]) nxt = ST_REL_A;
        else                 nxt = any_req ? ST_READ : ST_IDLE;
      end
      ST_REL_A: nxt = ST_REL_B;
      ST_REL_B: nxt = any_req ? ST_READ : ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      owner <= 1'b0;
      last  <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == ST_READ) begin
        owner <= win;
        last  <= win;
      end
    end
  end

  always_comb begin
    grant = 2'b00;
    if (state == ST_READ || state == ST_WRITE)
      grant = owner ? 2'b10 : 2'b01;
    case (state)
      ST_READ:            phase = PH_READ;
      ST_WRITE:           phase = PH_WRITE;
      ST_REL_A, ST_REL_B: phase = PH_REL;
      default:            phase = PH_IDLE;
    endcase
  end

  assign write_done = (state == ST_WRITE);

  // R3: at most one owner, and a read is always followed by its write
  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_no_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ) |=> (phase == PH_WRITE && $stable(grant)));
  // R7: destination-synchronized write releases the bus for two cycles
  assert_release_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WRITE && dst_sync[owner]) |=> (phase == PH_REL && grant == 2'b00) ##1 (phase == PH_REL && grant == 2'b00));
  // R8: the waiting channel takes the bus after a release
  assert_yield_to_ch0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REL_B && owner && req[0]) |=> (grant == 2'b01));
  assert_yield_to_ch1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REL_B && !owner && req[1]) |=> (grant == 2'b10));
  // R5: differing priorities from idle
  assert_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && req == 2'b11 && pri_hi == 2'b10) |=> (grant == 2'b10));
endmodule

// File: rtl/dual_dma_arbiter.sv
module dual_dma_arbiter
  import dual_dma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pin_req,
  input  logic            timer_req,
  input  logic [1:0]      req_sel,
  input  logic [1:0]      pri_hi,
  input  logic [3:0]      sync_mode,
  input  logic [3:0]      src_step,
  input  logic [3:0]      dst_step,
  input  logic [1:0]      word_size,
  input  logic [1:0]      ld_en,
  input  logic [AW-1:0]   ld_src,
  input  logic [AW-1:0]   ld_dst,
  output logic [1:0]      grant,
  output logic [1:0]      phase,
  output logic [AW-1:0]   bus_addr,
  output logic [2*AW-1:0] src_ptr,
  output logic [2*AW-1:0] dst_ptr
);
  localparam int NCH = 2;

  logic [NCH-1:0] req;
  logic [NCH-1:0] dst_sync;
  logic           owner;
  logic           write_done;

  dma_req_select #(.NCH(NCH)) u_sel (
    .pin_req   (pin_req),
    .timer_req (timer_req),
    .req_sel   (req_sel),
    .req       (req)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign dst_sync[i] = (sync_mode[2*i +: 2] == SYNC_DEST);

    dma_ptr_pair #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_en[i]),
      .ld_src   (ld_src),
      .ld_dst   (ld_dst),
      .step     (write_done && (owner == 1'(i))),
      .src_code (src_step[2*i +: 2]),
      .dst_code (dst_step[2*i +: 2]),
      .word     (word_size[i]),
      .src_q    (src_ptr[AW*i +: AW]),
      .dst_q    (dst_ptr[AW*i +: AW])
    );
  end

  dma_arb_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .pri_hi     (pri_hi),
    .dst_sync   (dst_sync),
    .owner      (owner),
    .grant      (grant),
    .phase      (phase),
    .write_done (write_done)
  );

  always_comb begin
    bus_addr = '0;
    if (phase == PH_READ)
      bus_addr = owner ? src_ptr[AW +: AW] : src_ptr[0 +: AW];
    else if (phase == PH_WRITE)
      bus_addr = owner ? dst_ptr[AW +: AW] : dst_ptr[0 +: AW];
  end
endmodule

// File: tb/dual_dma_arbiter_tb_top.sv
module dual_dma_arbiter_tb_top;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    pin_req = '0;
  logic          timer_req = 1'b0;
  logic [1:0]    req_sel = '0;
  logic [1:0]    pri_hi = '0;
  logic [3:0]    sync_mode = '0;
  logic [3:0]    src_step = '0;
  logic [3:0]    dst_step = '0;
  logic [1:0]    word_size = '0;
  logic [1:0]    ld_en = '0;
  logic [AW-1:0] ld_src = '0;
  logic [AW-1:0] ld_dst = '0;
  logic [1:0]    grant;
  logic [1:0]    phase;
  logic [AW-1:0] bus_addr;
  logic [2*AW-1:0] src_ptr;
  logic [2*AW-1:0] dst_ptr;

  dual_dma_arbiter #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .timer_req(timer_req),
    .req_sel(req_sel), .pri_hi(pri_hi), .sync_mode(sync_mode),
    .src_step(src_step), .dst_step(dst_step), .word_size(word_size),
    .ld_en(ld_en), .ld_src(ld_src), .ld_dst(ld_dst), .grant(grant),
    .phase(phase), .bus_addr(bus_addr), .src_ptr(src_ptr), .dst_ptr(dst_ptr)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic          ch;
    logic [AW-1:0] fa;
    logic [AW-1:0] da;
    int            gap;
    string         tag;
  } item_t;

  item_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic ch, input int fa, input int da, input int gap, input string tag);
    item_t it;
    it.ch = ch; it.fa = fa[AW-1:0]; it.da = da[AW-1:0]; it.gap = gap; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wait_write();
    do @(negedge clk); while (phase !== 2'd2);
  endtask

  task automatic load_ch(input int ch, input int s, input int d);
    @(negedge clk);
    ld_en = (ch == 0) ? 2'b01 : 2'b10;
    ld_src = s[AW-1:0];
    ld_dst = d[AW-1:0];
    @(negedge clk);
    ld_en = 2'b00;
  endtask

  // monitor / scoreboard
  int cyc = 0;
  int last_w = -100;
  logic [AW-1:0] cap_fa;
  logic [1:0]    cap_g;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (phase == 2'd1) begin
        cap_fa = bus_addr;
        cap_g  = grant;
      end else if (phase == 2'd2) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected transfer", int'(grant), 0);
        end else begin
          item_t it;
          logic [1:0] eg;
          it = exp_q.pop_front();
          eg = it.ch ? 2'b10 : 2'b01;
          chk(grant == eg && cap_g == eg, {it.tag, " owner"}, int'(grant), int'(eg));
          chk(cap_fa == it.fa, {it.tag, " R3 read addr"}, int'(cap_fa), int'(it.fa));
          chk(bus_addr == it.da, {it.tag, " R3 write addr"}, int'(bus_addr), int'(it.da));
          if (it.gap != 0)
            chk(cyc - last_w == it.gap, {it.tag, " spacing"}, cyc - last_w, it.gap);
        end
        last_w = cyc;
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(phase == 2'd0 && grant == 2'b00, "R1 phase/grant", {phase, grant}, 0);
    chk(src_ptr == '0 && dst_ptr == '0 && bus_addr == '0, "R1 pointers", int'(src_ptr), 0);

    // R10 loads
    load_ch(0, 'h10, 'h80);
    load_ch(1, 'h40, 'hC0);
    chk(src_ptr == 16'h4010 && dst_ptr == 16'hC080, "R10 load", int'(src_ptr), 'h4010);

    // A: ch0 source sync, byte increments, back-to-back (R4, R9)
    sync_mode = {2'd0, 2'd1}; src_step = {2'd0, 2'd1}; dst_step = {2'd2, 2'd1}; word_size = 2'b10;
    push(0, 'h10, 'h80, 0, "R4 A1");
    push(0, 'h11, 'h81, 2, "R4 A2");
    push(0, 'h12, 'h82, 2, "R4 A3");
    pin_req = 2'b01;
    repeat (3) wait_write();
    pin_req = 2'b00;
    @(negedge clk);
    chk(phase == 2'd0, "R4 idle after drop", int'(phase), 0);
    chk(src_ptr[7:0] == 8'h13 && dst_ptr[7:0] == 8'h83, "R9 ch0 inc byte", int'(src_ptr[7:0]), 'h13);

    // B: ch1 destination sync, word, src hold, dst down (R7, R9)
    sync_mode = {2'd2, 2'd1};
    push(1, 'h40, 'hC0, 0, "R7 B1");
    push(1, 'h40, 'hBE, 4, "R7 B2");
    pin_req = 2'b10;
    wait_write();
    @(negedge clk);
    chk(phase == 2'd3 && grant == 2'b00, "R7 release 1", {phase, grant}, 'hC);
    @(negedge clk);
    chk(phase == 2'd3 && grant == 2'b00, "R7 release 2", {phase, grant}, 'hC);
    wait_write();
    pin_req = 2'b00;
    repeat (4) @(negedge clk);

    // C: strict priority, ch0 high (R5)
    pri_hi = 2'b01;
    push(0, 'h13, 'h83, 0, "R5 C1");
    push(0, 'h14, 'h84, 2, "R5 C2");
    push(1, 'h40, 'hBC, 2, "R5 C3");
    pin_req = 2'b11;
    repeat (2) wait_write();
    pin_req = 2'b10;
    wait_write();
    pin_req = 2'b00;
    repeat (4) @(negedge clk);

    // D: ch1 high destination sync, ch0 low: alternation (R8)
    pri_hi = 2'b10;
    push(1, 'h40, 'hBA, 0, "R8 D1");
    push(0, 'h15, 'h85, 4, "R8 D2");
    push(1, 'h40, 'hB8, 2, "R8 D3");
    push(0, 'h16, 'h86, 4, "R8 D4");
    pin_req = 2'b11;
    repeat (4) wait_write();
    pin_req = 2'b00;
    repeat (3) @(negedge clk);

    // E: equal priority round robin, last was ch0 (R6)
    pri_hi = 2'b00; sync_mode = {2'd0, 2'd0};
    push(1, 'h40, 'hB6, 0, "R6 E1");
    push(0, 'h17, 'h87, 2, "R6 E2");
    push(1, 'h40, 'hB4, 2, "R6 E3");
    push(0, 'h18, 'h88, 2, "R6 E4");
    pin_req = 2'b11;
    repeat (4) wait_write();
    pin_req = 2'b00;
    repeat (3) @(negedge clk);

    // F: timer source for ch0, pin ignored, wrap (R2, R9)
    load_ch(0, 'hFF, 'h00);
    req_sel = 2'b01; pin_req = 2'b01;
    src_step = {2'd0, 2'd1}; dst_step = {2'd2, 2'd2}; word_size = 2'b11;
    sync_mode = {2'd1, 2'd1};
    repeat (5) begin
      @(negedge clk);
      chk(phase == 2'd0 && grant == 2'b00, "R2 pin ignored", int'(phase), 0);
    end
    push(0, 'hFF, 'h00, 0, "R2 F1");
    push(0, 'h01, 'hFE, 2, "R9 F2 wrap");
    timer_req = 1'b1;
    repeat (2) wait_write();
    timer_req = 1'b0;
    @(negedge clk);
    chk(src_ptr[7:0] == 8'h03 && dst_ptr[7:0] == 8'hFC, "R9 wrap pointers", int'(src_ptr[7:0]), 'h03);
    pin_req = 2'b00; req_sel = 2'b00;
    repeat (2) @(negedge clk);

    // G: high-priority ch1 preempts at the next boundary (R5)
    pri_hi = 2'b10;
    push(0, 'h03, 'hFC, 0, "R5 G1");
    push(0, 'h05, 'hFA, 2, "R5 G2 no split");
    push(1, 'h40, 'hB2, 2, "R5 G3 preempt");
    push(1, 'h40, 'hB0, 2, "R5 G4");
    push(0, 'h07, 'hF8, 2, "R5 G5 resume");
    pin_req = 2'b01;
    wait_write();
    @(negedge clk);
    pin_req = 2'b11;
    wait_write();
    repeat (2) wait_write();
    pin_req = 2'b01;
    wait_write();
    pin_req = 2'b00;
    repeat (5) @(negedge clk);

    chk(exp_q.size() == 0, "R3 all transfers seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule